// File: doc/BRIEF.md
# Power-Good Latched Frequency Selector

This block decides the operating point of a clock generator's divider network once, at power-up. Two select inputs are read when an active-low power-good strobe is first seen low after reset. The result is then held. One select input, FS_A, is a plain logic level. The other, FS_B, arrives already resolved from a three-level pad into low, mid or high. The block produces a mode code for the divider network, an output-enable indication, a test-mode flag, and a readback byte. The readback byte carries the captured select values to a register file.

In normal operation the captured pair picks a CPU clock frequency. A live configuration bit can switch to an alternate high-speed table. If FS_B is at mid level at the moment of capture, the block enters a sticky test mode. In test mode FS_A stays live and combinationally chooses between high-impedance outputs and reference-divided outputs. Only a reset leaves test mode.

Top module: `pgfs_top`

## Requirements
- R1: Between reset and capture, `mode` is 0 (not valid), `out_en` is 0, `test_mode` is 0 and `rb_byte` is 0.
- R2: `pwrgd_n` passes through two synchronizer flops before a capture register. Suppose it is driven low and held, starting before rising edge k. The outputs still read not valid after edge k+1, and show the captured result after edge k+2.
- R3: With `alt_tbl`=0 and FS_B not mid, the pair {FS_A, FS_B high} selects the `mode` value as follows:
  - 00 gives 1 (100 MHz).
  - 01 gives 4 (200 MHz).
  - 10 gives 2 (133 MHz).
  - 11 gives 3 (166 MHz).
  - In all four cases `out_en` is 1.
- R4: With `alt_tbl`=1, the same pair selects the `mode` value as follows. The bit is read live after capture.
  - 00 gives 4 (200 MHz).
  - 01 gives 7 (400 MHz).
  - 10 gives 5 (266 MHz).
  - 11 gives 6 (333 MHz).
- R5: After a normal capture, later changes on `pwrgd_n`, `fs_a` and `fs_b` do not change `mode` or `rb_byte`.
- R6: If `fs_b` is 2'b01 (mid) at capture, `test_mode` becomes 1.
- R7: In test mode, `fs_a`=1 gives `mode` 9 (high impedance) and `out_en` 0. `fs_a`=0 gives `mode` 8 (reference-divided) and `out_en` 1. `fs_a` acts combinationally. `fs_b` and `alt_tbl` have no effect in test mode.
- R8: Test mode and any captured value are cleared only by `rst_n` low; afterwards a new capture takes place.
- R9: `rb_byte` bit 0 holds the captured FS_A and bit 1 is 1 when the captured FS_B was high. Bits 7:2 are 0.
- R10: The `fs_b` encoding is 2'b00 low, 2'b01 mid and 2'b10 high; 2'b11 is treated as high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwrgd_n | input | 1 | Active-low power-good strobe, asynchronous |
| fs_a | input | 1 | Select input A |
| fs_b | input | 2 | Select input B, resolved three-level code |
| alt_tbl | input | 1 | Alternate high-speed table select |
| mode | output | 4 | Mode code for the divider network |
| out_en | output | 1 | Clock outputs driven (1) or high impedance (0) |
| test_mode | output | 1 | Test clock mode active |
| rb_byte | output | 8 | Readback byte with captured select values |

## Verification
The hardest state to reach is test mode with a live FS_A. Getting there takes a capture with FS_B at mid, which then locks the block until reset. The stimulus reaches it by capturing with mid, then toggling `fs_a` between clock edges so that its combinational effect is seen. It then moves `fs_b`, `alt_tbl` and `pwrgd_n` to show they are ignored, and finally resets to show that a normal capture is possible again. The two-edge synchronizer latency is checked by sampling one edge before and at the capture edge.

// File: rtl/pgfs_pkg.sv
package pgfs_pkg;
   localparam int MODE_W = 4;
   localparam int FSB_W  = 2;

   typedef enum logic [MODE_W-1:0] {
      M_NOT_VALID = 4'd0,
      M_CPU100    = 4'd1,
      M_CPU133    = 4'd2,
      M_CPU166    = 4'd3,
      M_CPU200    = 4'd4,
      M_CPU266    = 4'd5,
      M_CPU333    = 4'd6,
      M_CPU400    = 4'd7,
      M_TEST_REFN = 4'd8,
      M_TEST_HIZ  = 4'd9
   } mode_e;

   localparam logic [FSB_W-1:0] FSB_LOW  = 2'b00;
   localparam logic [FSB_W-1:0] FSB_MID  = 2'b01;
endpackage

// File: rtl/pgfs_sync.sv
module pgfs_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic d_out
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pgfs_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], d_in};
   end

   assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/pgfs_capture.sv
module pgfs_capture
   import pgfs_pkg::*;
#(
   parameter int B_W = FSB_W
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           pg_sync_n,
   input  logic           fs_a,
   input  logic [B_W-1:0] fs_b,
   output logic           captured,
   output logic           lat_a,
   output logic [B_W-1:0] lat_b
);
   generate
      if (B_W != 2) begin : g_bad_bw
         $error("pgfs_capture: B_W must be 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         captured <= 1'b0;
         lat_a    <= 1'b0;
         lat_b    <= '0;
      end else if (!captured && !pg_sync_n) begin
         captured <= 1'b1;
         lat_a    <= fs_a;
         lat_b    <= fs_b;
      end
   end

   AST_CAP_AFTER_SYNC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(captured) |-> !$past(pg_sync_n));                              // R2
   AST_CAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      captured |=> captured);                                              // R5
   AST_LATCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (captured && $past(captured)) |-> ($stable(lat_a) && $stable(lat_b))); // R5
endmodule

// File: rtl/pgfs_decode.sv
module pgfs_decode
   import pgfs_pkg::*;
#(
   parameter int RB_W    = 8,
   parameter int RB_ABIT = 0,
   parameter int RB_BBIT = 1
) (
   input  logic            captured,
   input  logic            lat_a,
   input  logic [FSB_W-1:0] lat_b,
   input  logic            live_a,
   input  logic            alt_tbl,
   output mode_e           mode,
   output logic            out_en,
   output logic            test_mode,
   output logic [RB_W-1:0] rb_byte
);
   generate
      if (RB_ABIT >= RB_W || RB_BBIT >= RB_W || RB_ABIT == RB_BBIT) begin : g_bad_rb
         $error("pgfs_decode: readback bit positions invalid");
      end
   endgenerate

   logic       b_high;
   logic       b_mid;
   logic [1:0] idx;

   assign b_high = lat_b[1];
   assign b_mid  = (lat_b == FSB_MID);
   assign idx    = {lat_a, b_high};

   always_comb begin
      mode      = M_NOT_VALID;
      out_en    = 1'b0;
      test_mode = 1'b0;
      if (captured) begin
         if (b_mid) begin
            test_mode = 1'b1;
            mode      = live_a ? M_TEST_HIZ : M_TEST_REFN;
            out_en    = !live_a;
         end else begin
            out_en = 1'b1;
            if (alt_tbl) begin
               case (idx)
                  2'b00:   mode = M_CPU200;
                  2'b01:   mode = M_CPU400;
                  2'b10:   mode = M_CPU266;
                  default: mode = M_CPU333;
               endcase
            end else begin
               case (idx)
                  2'b00:   mode = M_CPU100;
                  2'b01:   mode = M_CPU200;
                  2'b10:   mode = M_CPU133;
                  default: mode = M_CPU166;
               endcase
            end
         end
      end
   end

   for (genvar gi = 0; gi < RB_W; gi++) begin : g_rb
      if (gi == RB_ABIT) begin : g_a
         assign rb_byte[gi] = captured & lat_a;
      end else if (gi == RB_BBIT) begin : g_b
         assign rb_byte[gi] = captured & b_high;
      end else begin : g_z
         assign rb_byte[gi] = 1'b0;
      end
   end
endmodule

// File: rtl/pgfs_top.sv
module pgfs_top
   import pgfs_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int RB_W        = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwrgd_n,
   input  logic             fs_a,
   input  logic [1:0]       fs_b,
   input  logic             alt_tbl,
   output logic [3:0]       mode,
   output logic             out_en,
   output logic             test_mode,
   output logic [RB_W-1:0]  rb_byte
);
   logic             pg_sync_n;
   logic             captured;
   logic             lat_a;
   logic [FSB_W-1:0] lat_b;
   mode_e            mode_int;

   pgfs_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_in(pwrgd_n), .d_out(pg_sync_n));

   pgfs_capture #(.B_W(FSB_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .pg_sync_n(pg_sync_n), .fs_a(fs_a), .fs_b(fs_b),
      .captured(captured), .lat_a(lat_a), .lat_b(lat_b));

   pgfs_decode #(.RB_W(RB_W), .RB_ABIT(0), .RB_BBIT(1)) u_dec (
      .captured(captured), .lat_a(lat_a), .lat_b(lat_b), .live_a(fs_a),
      .alt_tbl(alt_tbl), .mode(mode_int), .out_en(out_en),
      .test_mode(test_mode), .rb_byte(rb_byte));

   assign mode = mode_int;

   AST_IDLE_NOT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !captured |-> (mode == 4'd0 && !out_en && rb_byte == '0));           // R1
   AST_TEST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(test_mode) |-> test_mode);                                     // R8
   AST_TEST_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
      (test_mode && fs_a) |-> (mode == 4'd9 && !out_en));                  // R7
   AST_TEST_FROM_MID: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(test_mode) |-> $past(fs_b) == 2'b01);                          // R6
endmodule

// File: tb/pgfs_top_test.sv
module pgfs_top_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pwrgd_n = 1'b1;
   logic       fs_a = 1'b0;
   logic [1:0] fs_b = 2'b00;
   logic       alt_tbl = 1'b0;
   logic [3:0] mode;
   logic       out_en;
   logic       test_mode;
   logic [7:0] rb_byte;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   typedef struct {
      logic [3:0] mode;
      logic       oe;
      logic       tm;
      logic [7:0] rb;
      string      req;
   } exp_t;

   exp_t exp_q[$];

   always #4 clk = ~clk;

   pgfs_top uut (
      .clk(clk), .rst_n(rst_n), .pwrgd_n(pwrgd_n), .fs_a(fs_a), .fs_b(fs_b),
      .alt_tbl(alt_tbl), .mode(mode), .out_en(out_en), .test_mode(test_mode),
      .rb_byte(rb_byte));

   // monitor: pops each expected item and compares against the ports
   initial begin
      forever begin
         wait (exp_q.size() != 0);
         #1;
         n_checks++;
         if (mode !== exp_q[0].mode || out_en !== exp_q[0].oe ||
             test_mode !== exp_q[0].tm || rb_byte !== exp_q[0].rb) begin
            n_fail++;
            $display("FAIL %s: got mode=%0d oe=%0b tm=%0b rb=%h, expected mode=%0d oe=%0b tm=%0b rb=%h",
                     exp_q[0].req, mode, out_en, test_mode, rb_byte,
                     exp_q[0].mode, exp_q[0].oe, exp_q[0].tm, exp_q[0].rb);
         end
         void'(exp_q.pop_front());
      end
   end

   task automatic expect_out(input logic [3:0] m, input logic oe, input logic tm,
                             input logic [7:0] rb, input string req);
      exp_t e;
      e.mode = m; e.oe = oe; e.tm = tm; e.rb = rb; e.req = req;
      exp_q.push_back(e);
      wait (exp_q.size() == 0);
   endtask

   function automatic logic [3:0] table_mode(input logic a, input logic bh, input logic alt);
      case ({alt, a, bh})
         3'b000: return 4'd1;
         3'b001: return 4'd4;
         3'b010: return 4'd2;
         3'b011: return 4'd3;
         3'b100: return 4'd4;
         3'b101: return 4'd7;
         3'b110: return 4'd5;
         default: return 4'd6;
      endcase
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; pwrgd_n = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      expect_out(4'd0, 1'b0, 1'b0, 8'h00, "R1");
   endtask

   // drive pwrgd_n low and check latency: not valid after 2 edges
   task automatic strobe(input logic a, input logic [1:0] b);
      fs_a = a; fs_b = b;
      pwrgd_n = 1'b0;
      repeat (2) @(negedge clk);
      expect_out(4'd0, 1'b0, 1'b0, 8'h00, "R2");
      @(negedge clk);
   endtask

   initial begin
      logic bh;
      do_reset();
      // R3 normal table, R9 readback, R2 latency
      for (int c = 0; c < 4; c++) begin
         do_reset();
         alt_tbl = 1'b0;
         strobe(c[1], c[0] ? 2'b10 : 2'b00);
         expect_out(table_mode(c[1], c[0], 1'b0), 1'b1, 1'b0,
                    {6'd0, c[0], c[1]}, "R3");
         // R4 alternate table read live after capture
         alt_tbl = 1'b1;
         @(negedge clk);
         expect_out(table_mode(c[1], c[0], 1'b1), 1'b1, 1'b0,
                    {6'd0, c[0], c[1]}, "R4");
         alt_tbl = 1'b0;
      end
      // R10: code 11 treated as high
      do_reset();
      strobe(1'b0, 2'b11);
      expect_out(4'd4, 1'b1, 1'b0, 8'h02, "R10");
      // R5: later input changes ignored
      fs_a = 1'b1; fs_b = 2'b01; pwrgd_n = 1'b1;
      repeat (4) @(negedge clk);
      pwrgd_n = 1'b0;
      repeat (4) @(negedge clk);
      expect_out(4'd4, 1'b1, 1'b0, 8'h02, "R5");
      fs_b = 2'b00;
      repeat (2) @(negedge clk);
      expect_out(4'd4, 1'b1, 1'b0, 8'h02, "R5");
      // R6 test mode from mid, R7 live fs_a
      do_reset();
      strobe(1'b1, 2'b01);
      expect_out(4'd9, 1'b0, 1'b1, 8'h01, "R6");
      fs_a = 1'b0;
      #2;
      expect_out(4'd8, 1'b1, 1'b1, 8'h01, "R7");
      @(negedge clk);
      fs_a = 1'b1;
      #2;
      expect_out(4'd9, 1'b0, 1'b1, 8'h01, "R7");
      @(negedge clk);
      fs_a = 1'b0; fs_b = 2'b10; alt_tbl = 1'b1; pwrgd_n = 1'b1;
      repeat (4) @(negedge clk);
      expect_out(4'd8, 1'b1, 1'b1, 8'h01, "R7");
      pwrgd_n = 1'b0; fs_b = 2'b00;
      repeat (4) @(negedge clk);
      expect_out(4'd8, 1'b1, 1'b1, 8'h01, "R8");
      // R8: only reset leaves test mode
      alt_tbl = 1'b0;
      do_reset();
      strobe(1'b1, 2'b10);
      bh = 1'b1;
      expect_out(table_mode(1'b1, bh, 1'b0), 1'b1, 1'b0, 8'h03, "R8");
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: got hung run, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule